// File: doc/BRIEF.md
# E1 Per-Timeslot Idle Code Inserter

This block sits in the serial transmit path of an E1 framer, after framing alignment and before line coding. Every clock it takes one bit of the outgoing transmit stream and one bit of a stream looped from the receive side. It decides, timeslot by timeslot, what goes out on the line. A frame is 32 timeslots of 8 bits. Each timeslot has its own select bit, and every timeslot can send its transmit data unchanged, a shared programmable 8-bit idle byte, or, in substitution mode, the receive-side data.

Software programs the block through a byte-wide write port. Four registers hold the 32 select bits, one holds the idle byte and one holds the global mode bit. A frame sync pulse marks the first bit of channel 1, and an internal bit counter tracks where each bit falls in the frame. Settings written over the port go into shadow registers. They are copied into the working set only at a timeslot boundary, so no timeslot ever carries a mix of old and new settings.

Top module: `e1_idle_inserter`

## Requirements
- R1: While reset is held and after it is released, the output is 0 until the first registered bit. With nothing written after reset, all select bits, the idle byte and the mode bit are zero, so the transmit bit passes through.
- R2: A frame is 256 bit periods. A cycle with `fsync_i` high carries bit 0 of channel 1. Without further sync pulses, the position keeps advancing and wraps from 255 to 0.
- R3: The select bits sit at byte addresses 0x26, 0x27, 0x28 and 0x29. Bit k (0 = LSB) of the register at 0x26+n selects channel 8n+k+1. Channel 1 is bit 0 at 0x26 and channel 32 is bit 7 at 0x29.
- R4: The idle byte is written at address 0x2A. In normal mode (mode bit 0), a channel whose select bit is 1 sends the idle byte MSB first: bit position 0 of the timeslot carries idle bit 7.
- R5: A channel whose select bit is 0 sends the transmit serial bit, in either mode.
- R6: The mode bit is bit 0 of the byte written at address 0x2B. When it is 1, a channel whose select bit is 1 sends the receive-side serial bit and no idle byte appears anywhere.
- R7: A write takes effect from the first timeslot that starts after the write cycle. The timeslot in progress keeps the settings it started with, even if the write lands in its last bit cycle.
- R8: The output is registered: the bit chosen from the inputs of one cycle appears on `ser_o` after the next rising clock edge.
- R9: Writes to any address other than 0x26 to 0x2B, and cycles with `wr_en_i` low, change no setting.
- R10: A sync pulse in the middle of a frame restarts the count at channel 1, bit 0, in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | High in the cycle that carries bit 0 of channel 1 |
| tx_ser_i | input | 1 | Transmit serial data bit |
| rx_ser_i | input | 1 | Receive-side serial data bit used in substitution mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ser_o | output | 1 | Registered outgoing serial bit |

## Verification
The assertions take it that clock, sync and both data streams are already aligned, and that a sync pulse lasts a single cycle. They also assume that reset is held across at least one rising edge before release, so the output mux properties start from a known working set. The stimulus drives every input on the falling edge and issues only one-cycle sync pulses, both on schedule and at arbitrary points mid-frame. Its writes fall at random bit positions, including the last bit of a timeslot. Addresses just outside the register window are also exercised, so that the boundary copy rule and the address decode are both stressed.

// File: rtl/e1_idle_pkg.sv
package e1_idle_pkg;

   // width of one programmable register and of one timeslot
   localparam int unsigned OCTET_W = 8;

   // where the outgoing bit of the current timeslot comes from
   typedef enum logic [1:0] {
      SRC_TX   = 2'd0,
      SRC_IDLE = 2'd1,
      SRC_RX   = 2'd2
   } src_e;

endpackage

// File: rtl/e1_slot_counter.sv
module e1_slot_counter #(
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned SLOT_BITS = 8,
   localparam int unsigned SLOT_W   = $clog2(SLOTS),
   localparam int unsigned BIT_W    = $clog2(SLOT_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_i,
   output logic [SLOT_W-1:0] slot_o,
   output logic [BIT_W-1:0]  bit_o,
   output logic              last_bit_o
);

   localparam int unsigned FRAME = SLOTS * SLOT_BITS;
   localparam int unsigned POS_W = SLOT_W + BIT_W;

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] cur;

   initial begin : g_param_chk
      assert (SLOTS > 1 && SLOTS == (1 << SLOT_W))
         else $error("SLOTS must be a power of two above 1");
      assert (SLOT_BITS > 1 && SLOT_BITS == (1 << BIT_W))
         else $error("SLOT_BITS must be a power of two above 1");
   end

   // a sync pulse forces the current cycle to frame position zero
   assign cur = fsync_i ? '0 : pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (cur == POS_W'(FRAME - 1)) begin
         pos_q <= '0;
      end else begin
         pos_q <= cur + 1'b1;
      end
   end

   assign slot_o     = cur[POS_W-1:BIT_W];
   assign bit_o      = cur[BIT_W-1:0];
   assign last_bit_o = (bit_o == BIT_W'(SLOT_BITS - 1));

   // R10: a sync pulse restarts the count, so the next cycle is position 1
   a_r10_sync_restart : assert property (@(posedge clk) disable iff (!rst_n)
      fsync_i |=> (pos_q == POS_W'(1)));

   // R2: the last frame position is followed by position zero
   a_r2_frame_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (!fsync_i && pos_q == POS_W'(FRAME - 1)) |=> (pos_q == '0));

endmodule

// File: rtl/e1_sel_bank.sv
module e1_sel_bank
   import e1_idle_pkg::*;
#(
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SEL_BASE  = 'h26,
   parameter int unsigned IDLE_ADDR = 'h2A,
   parameter int unsigned MODE_ADDR = 'h2B,
   parameter bit          SUBST_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [OCTET_W-1:0] wr_data_i,
   input  logic               load_i,
   output logic [SLOTS-1:0]   sel_o,
   output logic [OCTET_W-1:0] idle_o,
   output logic               mode_o
);

   localparam int unsigned NREG = SLOTS / OCTET_W;
   localparam logic [ADDR_W-1:0] IDLE_A = ADDR_W'(IDLE_ADDR);

   initial begin : g_param_chk
      assert (SLOTS % OCTET_W == 0 && NREG > 0)
         else $error("SLOTS must be a whole number of registers");
      assert (SEL_BASE + NREG <= (1 << ADDR_W) && IDLE_ADDR < (1 << ADDR_W))
         else $error("register addresses exceed the address width");
   end

   logic [SLOTS-1:0]   sel_sh_q, sel_sh_nxt, sel_act_q;
   logic [OCTET_W-1:0] idle_sh_q, idle_sh_nxt, idle_act_q;

   // one select register per group of eight channels
   for (genvar r = 0; r < NREG; r++) begin : g_selreg
      localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(SEL_BASE + r);
      assign sel_sh_nxt[r*OCTET_W +: OCTET_W] =
         (wr_en_i && wr_addr_i == REG_A) ? wr_data_i
                                         : sel_sh_q[r*OCTET_W +: OCTET_W];
   end

   assign idle_sh_nxt = (wr_en_i && wr_addr_i == IDLE_A) ? wr_data_i : idle_sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_sh_q   <= '0;
         sel_act_q  <= '0;
         idle_sh_q  <= '0;
         idle_act_q <= '0;
      end else begin
         sel_sh_q  <= sel_sh_nxt;
         idle_sh_q <= idle_sh_nxt;
         // the working set follows the shadow, this cycle's write included
         if (load_i) begin
            sel_act_q  <= sel_sh_nxt;
            idle_act_q <= idle_sh_nxt;
         end
      end
   end

   assign sel_o  = sel_act_q;
   assign idle_o = idle_act_q;

   if (SUBST_EN) begin : g_mode
      localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
      logic mode_sh_q, mode_sh_nxt, mode_act_q;

      assign mode_sh_nxt = (wr_en_i && wr_addr_i == MODE_A) ? wr_data_i[0] : mode_sh_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_sh_q  <= 1'b0;
            mode_act_q <= 1'b0;
         end else begin
            mode_sh_q <= mode_sh_nxt;
            if (load_i) begin
               mode_act_q <= mode_sh_nxt;
            end
         end
      end

      assign mode_o = mode_act_q;
   end else begin : g_no_mode
      assign mode_o = 1'b0;
   end

   // R7: the working set holds still except at a timeslot boundary
   a_r7_hold_mid_slot : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(sel_o) && $stable(idle_o) && $stable(mode_o)));

   // R7: a write in the boundary cycle is already in force for the next slot
   a_r7_boundary_write : assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && wr_en_i && wr_addr_i == IDLE_A) |=> (idle_o == $past(wr_data_i)));

endmodule

// File: rtl/e1_src_pick.sv
module e1_src_pick
   import e1_idle_pkg::*;
#(
   parameter bit SUBST_EN = 1'b1
) (
   input  logic chan_sel_i,
   input  logic mode_i,
   input  logic tx_i,
   input  logic rx_i,
   input  logic idle_bit_i,
   output logic bit_o
);

   src_e src;

   if (SUBST_EN) begin : g_subst
      always_comb begin
         if (!chan_sel_i)  src = SRC_TX;
         else if (mode_i)  src = SRC_RX;
         else              src = SRC_IDLE;
      end
   end else begin : g_plain
      always_comb begin
         src = chan_sel_i ? SRC_IDLE : SRC_TX;
      end
   end

   always_comb begin
      unique case (src)
         SRC_IDLE: bit_o = idle_bit_i;
         SRC_RX:   bit_o = rx_i;
         default:  bit_o = tx_i;
      endcase
   end

endmodule

// File: rtl/e1_idle_inserter.sv
module e1_idle_inserter
   import e1_idle_pkg::*;
#(
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned SLOT_BITS = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SEL_BASE  = 'h26,
   parameter int unsigned IDLE_ADDR = 'h2A,
   parameter int unsigned MODE_ADDR = 'h2B,
   parameter bit          SUBST_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fsync_i,
   input  logic               tx_ser_i,
   input  logic               rx_ser_i,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [OCTET_W-1:0] wr_data_i,
   output logic               ser_o
);

   localparam int unsigned SLOT_W = $clog2(SLOTS);
   localparam int unsigned BIT_W  = $clog2(SLOT_BITS);

   initial begin : g_param_chk
      assert (SLOT_BITS == OCTET_W)
         else $error("a timeslot must be as wide as the idle register");
   end

   logic [SLOT_W-1:0]  slot_idx;
   logic [BIT_W-1:0]   bit_idx;
   logic               slot_end;
   logic [SLOTS-1:0]   sel_act;
   logic [OCTET_W-1:0] idle_act;
   logic               mode_act;
   logic               chan_sel;
   logic               idle_bit;
   logic               pick_bit;

   e1_slot_counter #(
      .SLOTS     (SLOTS),
      .SLOT_BITS (SLOT_BITS)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsync_i    (fsync_i),
      .slot_o     (slot_idx),
      .bit_o      (bit_idx),
      .last_bit_o (slot_end)
   );

   e1_sel_bank #(
      .SLOTS     (SLOTS),
      .ADDR_W    (ADDR_W),
      .SEL_BASE  (SEL_BASE),
      .IDLE_ADDR (IDLE_ADDR),
      .MODE_ADDR (MODE_ADDR),
      .SUBST_EN  (SUBST_EN)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .load_i    (slot_end),
      .sel_o     (sel_act),
      .idle_o    (idle_act),
      .mode_o    (mode_act)
   );

   // the idle byte leaves most significant bit first
   assign chan_sel = sel_act[slot_idx];
   assign idle_bit = idle_act[BIT_W'(OCTET_W - 1) - bit_idx];

   e1_src_pick #(
      .SUBST_EN (SUBST_EN)
   ) u_pick (
      .chan_sel_i (chan_sel),
      .mode_i     (mode_act),
      .tx_i       (tx_ser_i),
      .rx_i       (rx_ser_i),
      .idle_bit_i (idle_bit),
      .bit_o      (pick_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ser_o <= 1'b0;
      else        ser_o <= pick_bit;
   end

   // R1: the first edge after reset release still shows the reset value
   a_r1_reset_low : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ser_o == 1'b0));

   // R5: an unselected channel carries the transmit bit one clock later
   a_r5_pass_tx : assert property (@(posedge clk) disable iff (!rst_n)
      !chan_sel |=> (ser_o == $past(tx_ser_i)));

   // R4: a selected channel in normal mode carries the idle byte bit
   a_r4_idle_bit : assert property (@(posedge clk) disable iff (!rst_n)
      (chan_sel && !mode_act) |=> (ser_o == $past(idle_bit)));

   // R6: a selected channel in substitution mode carries the receive bit
   a_r6_subst_rx : assert property (@(posedge clk) disable iff (!rst_n)
      (chan_sel && mode_act) |=> (ser_o == $past(rx_ser_i)));

endmodule

// File: tb/e1_idle_inserter_tb.sv
module e1_idle_inserter_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fsync_i = 1'b0;
   logic       tx_ser_i = 1'b0;
   logic       rx_ser_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_addr_i = 8'h00;
   logic [7:0] wr_data_i = 8'h00;
   logic       ser_o;

   int checks = 0;
   int errors = 0;
   string phase = "R1";

   always #4 clk = ~clk;

   e1_idle_inserter u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .fsync_i   (fsync_i),
      .tx_ser_i  (tx_ser_i),
      .rx_ser_i  (rx_ser_i),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .ser_o     (ser_o)
   );

   // behavioural reference: frame position, shadow and working settings
   int        m_pos;
   bit [31:0] m_sel_sh, m_sel_wk;
   bit [7:0]  m_idle_sh, m_idle_wk;
   bit        m_mode_sh, m_mode_wk;
   bit        m_exp;
   string     m_tag;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0;
         m_sel_sh = '0;  m_sel_wk = '0;
         m_idle_sh = '0; m_idle_wk = '0;
         m_mode_sh = 0;  m_mode_wk = 0;
         m_exp = 0;      m_tag = "R1";
      end else begin
         int cur, ch, b;
         cur = fsync_i ? 0 : m_pos;
         ch  = cur / 8;
         b   = cur % 8;
         if (m_sel_wk[ch] && m_mode_wk) begin
            m_exp = rx_ser_i; m_tag = "R6";
         end else if (m_sel_wk[ch]) begin
            m_exp = m_idle_wk[7 - b]; m_tag = "R4";
         end else begin
            m_exp = tx_ser_i; m_tag = "R5";
         end
         if (wr_en_i) begin
            if (wr_addr_i >= 8'h26 && wr_addr_i <= 8'h29)
               m_sel_sh[(int'(wr_addr_i) - 'h26) * 8 +: 8] = wr_data_i;
            else if (wr_addr_i == 8'h2A)
               m_idle_sh = wr_data_i;
            else if (wr_addr_i == 8'h2B)
               m_mode_sh = wr_data_i[0];
         end
         if (b == 7) begin
            m_sel_wk = m_sel_sh; m_idle_wk = m_idle_sh; m_mode_wk = m_mode_sh;
         end
         m_pos = (cur + 1) % 256;
      end
   end

   task automatic check_bit(input string req, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: ser_o=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // one bit period: compare the previous edge's result, then drive new inputs
   task automatic step(input bit fs, input bit we, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      check_bit({phase, "/", m_tag}, ser_o, m_exp);
      fsync_i   = fs;
      tx_ser_i  = 1'($urandom);
      rx_ser_i  = 1'($urandom);
      wr_en_i   = we;
      wr_addr_i = a;
      wr_data_i = d;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 8'h00);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      step(1'b0, 1'b1, a, d);
   endtask

   initial begin
      // R1: output held low during reset
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check_bit("R1", ser_o, 1'b0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1", ser_o, 1'b0);

      phase = "R8";
      run(40);

      phase = "R2";
      step(1'b1, 1'b0, 8'h00, 8'h00);
      wr(8'h2A, 8'hA5);
      wr(8'h26, 8'h01);
      run(600);

      phase = "R3";
      wr(8'h29, 8'h80);
      wr(8'h27, 8'h02);
      wr(8'h28, 8'h10);
      run(600);

      phase = "R4";
      wr(8'h2A, 8'h3C);
      wr(8'h27, 8'hFF);
      run(300);

      phase = "R7";
      for (int i = 0; i < 120; i++) begin
         int gap;
         gap = int'($urandom_range(0, 8));
         wr(8'h26 + 8'($urandom_range(0, 4)), 8'($urandom));
         run(gap);
      end

      phase = "R6";
      wr(8'h2B, 8'h01);
      for (int i = 0; i < 60; i++) begin
         wr(8'h26 + 8'($urandom_range(0, 3)), 8'($urandom));
         run(10);
      end

      phase = "R9";
      wr(8'h2B, 8'h00);
      wr(8'h2A, 8'h96);
      run(20);
      for (int i = 0; i < 40; i++) begin
         wr(8'h25, 8'hFF);
         wr(8'h2C, 8'hFF);
         wr(8'h00, 8'h5A);
         wr(8'hA6, 8'hFF);
         step(1'b0, 1'b0, 8'h2A, 8'h00);
         run(5);
      end

      phase = "R10";
      for (int i = 0; i < 12; i++) begin
         run(int'($urandom_range(3, 90)));
         step(1'b1, 1'b0, 8'h00, 8'h00);
      end
      run(300);

      phase = "R5";
      wr(8'h26, 8'h00);
      wr(8'h27, 8'h00);
      wr(8'h28, 8'h00);
      wr(8'h29, 8'h00);
      run(300);
      step(1'b0, 1'b0, 8'h00, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule